// File: doc/BRIEF.md
# UART Interrupt Status Combiner

This block keeps the eleven raw interrupt status bits of a serial port together with an interrupt mask, and it drives six active-high interrupt lines. Detectors elsewhere in the port pulse one input bit per source for one cycle to record an event. Two register-write strobes, each with an 11-bit data word, let software load the mask or clear chosen status bits. The raw and masked status words are returned for register reads.

The eleven sources fall into groups. Four error sources drive the error line. Four modem-status sources drive the modem line. Receive, transmit and receive-timeout each have a line of their own. A combined line is high whenever any source is both pending and enabled. Every line is a flop. Each line is computed from the same next-state values that load the status and mask registers, so a line changes in the same cycle as the masked status word it is derived from.

Top module: `uirq_combiner`

## Requirements
- R1: A one on bit i of `set_pulse` makes `raw_status` bit i read one in the following cycle. The bit positions are: overrun 10, break 9, parity 8, framing 7, receive timeout 6, transmit 5, receive 4, DSR 3, DCD 2, CTS 1, ring indicator 0.
- R2: `masked_status` always equals `raw_status` ANDed bitwise with the mask register.
- R3: `irq_err` is high exactly when at least one of masked bits 10, 9, 8 or 7 is high.
- R4: `irq_modem` is high exactly when at least one of masked bits 3, 2, 1 or 0 is high.
- R5: `irq_rx` follows masked bit 4, `irq_tx` follows masked bit 5, and `irq_rtmo` follows masked bit 6.
- R6: `irq_any` is high exactly when at least one of the eleven masked bits is high.
- R7: A cycle with `clr_we` high clears each raw bit whose `clr_wdata` bit is one, from the next cycle on. Raw bits whose `clr_wdata` bit is zero keep their values. When `clr_we` is low, raw bits change only through set pulses.
- R8: A cycle with `mask_we` high replaces the whole mask with `mask_wdata`. In the next cycle `masked_status` and all six lines reflect the new mask. When `mask_we` is low, the mask holds.
- R9: When a set pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R10: During reset and in the first cycle after it, the raw status, the mask, `masked_status` and all six lines are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| set_pulse | input | 11 | One-cycle event pulses, one bit per source |
| mask_we | input | 1 | Write strobe for the mask register |
| mask_wdata | input | 11 | New mask value |
| clr_we | input | 1 | Write strobe for the clear register |
| clr_wdata | input | 11 | Bits to clear in the raw status |
| raw_status | output | 11 | Raw pending status |
| masked_status | output | 11 | Raw status ANDed with the mask |
| irq_any | output | 1 | Combined interrupt line |
| irq_rx | output | 1 | Receive interrupt line |
| irq_tx | output | 1 | Transmit interrupt line |
| irq_rtmo | output | 1 | Receive-timeout interrupt line |
| irq_modem | output | 1 | Modem-status interrupt line |
| irq_err | output | 1 | Error interrupt line |

## Verification
The hardest case to reach from the ports is a single cycle in which a set pulse, a clear write on the same bit and a mask change all arrive together. In that cycle the next-state logic has to resolve the set-wins rule and pick up the new mask before either register has updated. The bench loads known status, then drives all three strobes in one cycle over chosen bit patterns and checks every line in the following cycle. A sweep over every pairing of one pending source with one enabled mask bit then shows that each line picks up only its own group.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int SRC_W  = 11;
    localparam int LINE_N = 6;

    // Status bit positions
    localparam int B_RI   = 0;
    localparam int B_CTS  = 1;
    localparam int B_DCD  = 2;
    localparam int B_DSR  = 3;
    localparam int B_RX   = 4;
    localparam int B_TX   = 5;
    localparam int B_RTMO = 6;
    localparam int B_FRM  = 7;
    localparam int B_PAR  = 8;
    localparam int B_BRK  = 9;
    localparam int B_OVR  = 10;

    typedef logic [SRC_W-1:0] src_vec_t;

    typedef enum logic [2:0] {
        LN_ANY   = 3'd0,
        LN_RX    = 3'd1,
        LN_TX    = 3'd2,
        LN_RTMO  = 3'd3,
        LN_MODEM = 3'd4,
        LN_ERR   = 3'd5
    } line_e;

    typedef struct packed {
        logic err;
        logic modem;
        logic rtmo;
        logic tx;
        logic rx;
        logic any;
    } irq_lines_t;

    function automatic src_vec_t bit_of(int pos);
        src_vec_t v;
        v = '0;
        v[pos] = 1'b1;
        return v;
    endfunction

    // Sources that feed each output line
    function automatic src_vec_t line_sources(line_e ln);
        case (ln)
            LN_ANY:   return '1;
            LN_RX:    return bit_of(B_RX);
            LN_TX:    return bit_of(B_TX);
            LN_RTMO:  return bit_of(B_RTMO);
            LN_MODEM: return bit_of(B_RI) | bit_of(B_CTS) | bit_of(B_DCD) | bit_of(B_DSR);
            LN_ERR:   return bit_of(B_FRM) | bit_of(B_PAR) | bit_of(B_BRK) | bit_of(B_OVR);
            default:  return '0;
        endcase
    endfunction

endpackage

// File: rtl/uirq_status_reg.sv
module uirq_status_reg
    import uirq_pkg::*;
#(
    parameter int W = SRC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic         clr_we,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] raw_d_o,
    output logic [W-1:0] raw_q_o
);
    logic [W-1:0] clr_eff;
    logic [W-1:0] raw_q;

    always_comb begin
        clr_eff = clr_we ? clr_data : '0;
        // the set term is ORed in last, so a set wins over a clear
        raw_d_o = (raw_q & ~clr_eff) | set_i;
        if (rst) raw_d_o = '0;
    end

    always_ff @(posedge clk) begin
        raw_q <= raw_d_o;
    end

    assign raw_q_o = raw_q;
endmodule

// File: rtl/uirq_mask_reg.sv
module uirq_mask_reg
    import uirq_pkg::*;
#(
    parameter int W = SRC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_d_o,
    output logic [W-1:0] mask_q_o
);
    logic [W-1:0] mask_q;

    always_comb begin
        mask_d_o = we ? wdata : mask_q;
        if (rst) mask_d_o = '0;
    end

    always_ff @(posedge clk) begin
        mask_q <= mask_d_o;
    end

    assign mask_q_o = mask_q;
endmodule

// File: rtl/uirq_line_map.sv
module uirq_line_map
    import uirq_pkg::*;
#(
    parameter int W = SRC_W,
    parameter int N = LINE_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] masked_d,
    output logic [N-1:0] lines_q
);
    for (genvar ln = 0; ln < N; ln++) begin : g_line
        localparam src_vec_t SEL = line_sources(line_e'(ln));
        always_ff @(posedge clk) begin
            if (rst) lines_q[ln] <= 1'b0;
            else     lines_q[ln] <= |(masked_d & SEL);
        end
    end
endmodule

// File: rtl/uirq_combiner.sv
module uirq_combiner
    import uirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_W-1:0] set_pulse,
    input  logic             mask_we,
    input  logic [SRC_W-1:0] mask_wdata,
    input  logic             clr_we,
    input  logic [SRC_W-1:0] clr_wdata,
    output logic [SRC_W-1:0] raw_status,
    output logic [SRC_W-1:0] masked_status,
    output logic             irq_any,
    output logic             irq_rx,
    output logic             irq_tx,
    output logic             irq_rtmo,
    output logic             irq_modem,
    output logic             irq_err
);
    src_vec_t   raw_d, raw_q, mask_d, mask_q, masked_d;
    irq_lines_t lines;

    uirq_status_reg #(.W(SRC_W)) u_status (
        .clk(clk), .rst(rst), .set_i(set_pulse),
        .clr_we(clr_we), .clr_data(clr_wdata),
        .raw_d_o(raw_d), .raw_q_o(raw_q)
    );

    uirq_mask_reg #(.W(SRC_W)) u_mask (
        .clk(clk), .rst(rst), .we(mask_we), .wdata(mask_wdata),
        .mask_d_o(mask_d), .mask_q_o(mask_q)
    );

    // Lines are computed from next-state values so they line up with masked_status
    assign masked_d = raw_d & mask_d;

    uirq_line_map #(.W(SRC_W), .N(LINE_N)) u_lines (
        .clk(clk), .rst(rst), .masked_d(masked_d), .lines_q(lines)
    );

    assign raw_status    = raw_q;
    assign masked_status = raw_q & mask_q;
    assign irq_any       = lines.any;
    assign irq_rx        = lines.rx;
    assign irq_tx        = lines.tx;
    assign irq_rtmo      = lines.rtmo;
    assign irq_modem     = lines.modem;
    assign irq_err       = lines.err;
endmodule

// File: rtl/uirq_combiner_chk.sv
module uirq_combiner_chk
    import uirq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [SRC_W-1:0] set_pulse,
    input logic             mask_we,
    input logic [SRC_W-1:0] mask_wdata,
    input logic             clr_we,
    input logic [SRC_W-1:0] clr_wdata,
    input logic [SRC_W-1:0] raw_status,
    input logic [SRC_W-1:0] masked_status,
    input logic [SRC_W-1:0] mask_q,
    input logic             irq_any,
    input logic             irq_rx,
    input logic             irq_tx,
    input logic             irq_rtmo,
    input logic             irq_modem,
    input logic             irq_err
);
    localparam logic [SRC_W-1:0] ERR_SET   = 11'h780;
    localparam logic [SRC_W-1:0] MODEM_SET = 11'h00F;

    assert_set_R1: assert property (@(posedge clk) disable iff (rst)
        (|set_pulse) |=> ((raw_status & $past(set_pulse)) == $past(set_pulse)));

    assert_masked_R2: assert property (@(posedge clk) disable iff (rst)
        masked_status == (raw_status & mask_q));

    assert_err_line_R3: assert property (@(posedge clk) disable iff (rst)
        irq_err == |(masked_status & ERR_SET));

    assert_modem_line_R4: assert property (@(posedge clk) disable iff (rst)
        irq_modem == |(masked_status & MODEM_SET));

    assert_single_lines_R5: assert property (@(posedge clk) disable iff (rst)
        irq_rx == masked_status[4] && irq_tx == masked_status[5] && irq_rtmo == masked_status[6]);

    assert_any_line_R6: assert property (@(posedge clk) disable iff (rst)
        irq_any == (|masked_status));

    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((raw_status & $past(clr_wdata & ~set_pulse)) == '0));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !clr_we |=> ((raw_status & ~$past(set_pulse)) == ($past(raw_status) & ~$past(set_pulse))));

    assert_mask_write_R8: assert property (@(posedge clk) disable iff (rst)
        mask_we |=> (masked_status == (raw_status & $past(mask_wdata))));

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_we && |(clr_wdata & set_pulse)) |=>
            ((raw_status & $past(clr_wdata & set_pulse)) == $past(clr_wdata & set_pulse)));

    assert_reset_R10: assert property (@(posedge clk)
        $past(rst) |-> (raw_status == '0 && masked_status == '0 &&
                        !irq_any && !irq_err && !irq_modem && !irq_rx && !irq_tx && !irq_rtmo));
endmodule

bind uirq_combiner uirq_combiner_chk u_chk (
    .clk(clk), .rst(rst), .set_pulse(set_pulse),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .clr_we(clr_we), .clr_wdata(clr_wdata),
    .raw_status(raw_status), .masked_status(masked_status), .mask_q(mask_q),
    .irq_any(irq_any), .irq_rx(irq_rx), .irq_tx(irq_tx),
    .irq_rtmo(irq_rtmo), .irq_modem(irq_modem), .irq_err(irq_err)
);

// File: tb/uirq_combiner_tb.sv
module uirq_combiner_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] set_pulse = '0;
    logic        mask_we = 1'b0;
    logic [10:0] mask_wdata = '0;
    logic        clr_we = 1'b0;
    logic [10:0] clr_wdata = '0;
    logic [10:0] raw_status, masked_status;
    logic        irq_any, irq_rx, irq_tx, irq_rtmo, irq_modem, irq_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [10:0] m_raw  = '0;
    logic [10:0] m_mask = '0;

    always #2 clk = ~clk;

    uirq_combiner u_dut (
        .clk(clk), .rst(rst), .set_pulse(set_pulse),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .clr_we(clr_we), .clr_wdata(clr_wdata),
        .raw_status(raw_status), .masked_status(masked_status),
        .irq_any(irq_any), .irq_rx(irq_rx), .irq_tx(irq_tx),
        .irq_rtmo(irq_rtmo), .irq_modem(irq_modem), .irq_err(irq_err)
    );

    task automatic cmp(input string req, input logic [10:0] act, input logic [10:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // All outputs against the model, each named by its requirement
    task automatic check_all();
        logic [10:0] m;
        m = m_raw & m_mask;
        cmp("R1 raw_status",    raw_status, m_raw);
        cmp("R2 masked_status", masked_status, m);
        cmp("R3 irq_err",   {10'd0, irq_err},   {10'd0, (m[10] | m[9] | m[8] | m[7])});
        cmp("R4 irq_modem", {10'd0, irq_modem}, {10'd0, (m[3] | m[2] | m[1] | m[0])});
        cmp("R5 irq_rx",    {10'd0, irq_rx},    {10'd0, m[4]});
        cmp("R5 irq_tx",    {10'd0, irq_tx},    {10'd0, m[5]});
        cmp("R5 irq_rtmo",  {10'd0, irq_rtmo},  {10'd0, m[6]});
        cmp("R6 irq_any",   {10'd0, irq_any},   {10'd0, (m != 11'd0)});
    endtask

    // One clock: inputs applied after a falling edge, checked at the next one
    task automatic cyc(input logic [10:0] s, input logic mw, input logic [10:0] md,
                       input logic cw, input logic [10:0] cd);
        set_pulse = s; mask_we = mw; mask_wdata = md; clr_we = cw; clr_wdata = cd;
        @(posedge clk);
        m_raw = (m_raw & ~(cw ? cd : 11'd0)) | s;
        if (mw) m_mask = md;
        @(negedge clk);
        set_pulse = '0; mask_we = 1'b0; mask_wdata = '0; clr_we = 1'b0; clr_wdata = '0;
        check_all();
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R10: reset with stimulus present
        set_pulse = '1; mask_we = 1'b1; mask_wdata = '1;
        repeat (3) @(negedge clk);
        set_pulse = '0; mask_we = 1'b0; mask_wdata = '0;
        rst = 1'b0;
        @(negedge clk);
        cmp("R10 raw after reset", raw_status, 11'd0);
        check_all();

        // R1/R3-R6: each source alone, full mask
        cyc(11'd0, 1'b1, 11'h7FF, 1'b0, 11'd0);
        for (int i = 0; i < 11; i++) begin
            cyc(11'd1 << i, 1'b0, 11'd0, 1'b0, 11'd0);
            cyc(11'd0, 1'b0, 11'd0, 1'b1, 11'h7FF);
        end

        // R2/R8: every pending source against every single-bit mask
        for (int i = 0; i < 11; i++) begin
            for (int j = 0; j < 11; j++) begin
                cyc(11'd0, 1'b1, 11'd1 << j, 1'b1, 11'h7FF);
                cyc(11'd1 << i, 1'b0, 11'd0, 1'b0, 11'd0);
                cyc(11'd0, 1'b0, 11'd0, 1'b0, 11'd0); // R8 mask holds
            end
        end

        // R7: partial clears leave other bits alone
        cyc(11'h7FF, 1'b1, 11'h7FF, 1'b0, 11'd0);
        cyc(11'd0, 1'b0, 11'd0, 1'b1, 11'h555);
        cyc(11'd0, 1'b0, 11'd0, 1'b1, 11'h0F0);
        cyc(11'd0, 1'b0, 11'd0, 1'b0, 11'h7FF);   // strobe low: R7 no clear
        cyc(11'd0, 1'b0, 11'd0, 1'b1, 11'h7FF);

        // R9: set and clear together, plus mask change in the same cycle
        for (int k = 0; k < 16; k++) begin
            logic [10:0] pre, s, c, mk;
            pre = 11'((k * 11'h2B7) ^ 11'h5A3);
            s   = 11'((k * 11'h1C9) + 11'h041);
            c   = 11'((k * 11'h3D5) ^ 11'h7F0);
            mk  = 11'((k * 11'h24F) ^ 11'h0CC);
            cyc(pre, 1'b0, 11'd0, 1'b0, 11'd0);
            cyc(s, 1'b1, mk, 1'b1, c | s);
            cmp("R9 set wins", raw_status & s, s);
            cyc(11'd0, 1'b0, 11'd0, 1'b1, 11'h7FF);
        end

        // R10: reset again from a busy state
        cyc(11'h7FF, 1'b1, 11'h7FF, 1'b0, 11'd0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_raw = '0; m_mask = '0;
        @(negedge clk);
        cmp("R10 mask cleared by reset", masked_status, 11'd0);
        cyc(11'h7FF, 1'b0, 11'd0, 1'b0, 11'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule